// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a memory-mapped watchdog timer. Software on a fast bus clock writes its registers, and the timing logic runs on a slow tick clock of about 32 kHz. When the up-counter passes its all-ones value while the timer is armed, the block sends a one-cycle reset request on the slow clock and restarts counting from a programmed reload value. Software keeps the system alive by writing the kick register. Every kick must carry a value that differs from the previous kick, so software normally alternates between a word and its bitwise complement.

Each write from the bus side is posted. It is held in a per-register channel and carried into the slow domain by a toggle request and acknowledge. Its bit in the pending register stays set until the acknowledge comes back. Arming and disarming each take two key words in a fixed order. Any other second word throws the half-finished sequence away. An optional prescaler divides the tick by a power of two before it reaches the counter.

Top module: `seqlock_wdt`

## Requirements
- R1: Reading word address 0 (identity) returns the REV_CODE parameter in bits 7:0 and zero in every other bit.
- R2: Writing 0xBBBB and then 0x4444 to the arm register (address 5) arms the timer. Reading address 5 returns the armed state in bit 0 and zero above it. The key compare uses the whole written word.
- R3: Writing 0xAAAA and then 0x5555 to the arm register disarms the timer.
- R4: If the arm write after a first key word is not that word's partner, the sequence is dropped and the armed state is left as it was. A lone partner word, with no first word before it, also has no effect.
- R5: The pending register (address 6) has a busy bit for each posted register: bit 0 control (address 1), bit 2 reload (address 3), bit 3 kick (address 4), bit 4 arm (address 5). A bit sets in the cycle after an accepted write and clears only after the slow domain has acknowledged that write. A write to a register whose bit is set is discarded. Reading a posted register returns the last accepted word.
- R6: In the control word, bit 5 enables the prescaler and bits 4:2 hold the prescale exponent P. With the prescaler on, the counter steps once every 2^P ticks. With it off, the counter steps on every tick and P has no effect.
- R7: While armed, the counter (read at address 2) counts upward. While disarmed, it holds its value. After reset it reads zero.
- R8: When an armed counter steps from all ones, the block raises rst_req for one slow cycle and reloads from the reload register. Reset requests are spaced (2^COUNT_W - reload) × step period apart.
- R9: A kick whose value differs from the previous kick value reloads the counter from the reload register. A kick that repeats the previous value does nothing. The previous kick value is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-access clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus side |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 3 | Word address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr (combinational) |
| slow_clk | input | 1 | Slow tick clock |
| slow_rst_n | input | 1 | Asynchronous active-low reset, slow side |
| rst_req | output | 1 | One-slow-cycle reset request on overflow |

## Verification
The bench builds the block with an 8-bit counter and keeps the 3-bit prescale field. With an 8-bit counter, a reload of 0xF8 overflows after only eight steps, so the bench can sweep all eight prescale exponents and then the unscaled case, and compare each reset-request spacing with the product it computes. It then steps the reload value through 0x00, 0x80, 0xF0 and 0xFF. At 0xFF the requests come on every slow cycle. The small counter also lets the kick and key-sequence checks read exact counter values through the synchronized counter port.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int ADDR_W = 3;
    localparam int NCHAN  = 4;
    localparam int PEND_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_IDENT = 3'd0,
        A_CTRL  = 3'd1,
        A_COUNT = 3'd2,
        A_LOAD  = 3'd3,
        A_KICK  = 3'd4,
        A_ARM   = 3'd5,
        A_PEND  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_ON_HALF  = 2'd1,
        SEQ_OFF_HALF = 2'd2
    } seq_e;

    localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
    localparam logic [15:0] KEY_ON_B  = 16'h4444;
    localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_B = 16'h5555;

    // Channel order: 0 control, 1 reload, 2 kick, 3 arm
    function automatic logic [ADDR_W-1:0] chan_addr(input int idx);
        case (idx)
            0:       return A_CTRL;
            1:       return A_LOAD;
            2:       return A_KICK;
            default: return A_ARM;
        endcase
    endfunction

    function automatic int chan_pend_bit(input int idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] held_o,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic              apply_o
);

    typedef struct packed {
        logic              req;
        logic              ack_m;
        logic              ack_s;
        logic [DATA_W-1:0] held;
    } bus_st_t;

    typedef struct packed {
        logic req_m;
        logic req_s;
        logic seen;
    } slow_st_t;

    bus_st_t  b_d, b_q;
    slow_st_t s_d, s_q;

    always_comb begin
        b_d       = b_q;
        b_d.ack_m = s_q.seen;
        b_d.ack_s = b_q.ack_m;
        if (wr_i) begin
            b_d.req  = ~b_q.req;
            b_d.held = wdata_i;
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) b_q <= '0;
        else            b_q <= b_d;
    end

    always_comb begin
        s_d.req_m = b_q.req;
        s_d.req_s = s_q.req_m;
        s_d.seen  = s_q.req_s;
    end

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) s_q <= '0;
        else             s_q <= s_d;
    end

    assign busy_o  = b_q.req ^ b_q.ack_s;
    assign held_o  = b_q.held;
    assign apply_o = s_q.req_s ^ s_q.seen;

endmodule

// File: rtl/wdt_slow_core.sv
module wdt_slow_core
    import wdt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 32,
    parameter int PTV_W   = 3
) (
    input  logic               slow_clk,
    input  logic               slow_rst_n,
    input  logic               ctrl_apply,
    input  logic               ctrl_en,
    input  logic [PTV_W-1:0]   ctrl_ptv,
    input  logic               load_apply,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               kick_apply,
    input  logic [DATA_W-1:0]  kick_val,
    input  logic               arm_apply,
    input  logic [DATA_W-1:0]  arm_val,
    output logic [COUNT_W-1:0] count_gray_o,
    output logic               running_o,
    output seq_e               seq_o,
    output logic               rst_req_o
);

    localparam int DIV_W = (1 << PTV_W) - 1;

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic [COUNT_W-1:0] gray;
        logic [COUNT_W-1:0] load;
        logic [DATA_W-1:0]  last_kick;
        logic               pre_en;
        logic [PTV_W-1:0]   ptv;
        logic [DIV_W-1:0]   div;
        logic               run;
        seq_e               seq;
        logic               rst_req;
    } core_st_t;

    core_st_t c_d, c_q;
    logic [DIV_W-1:0] div_lim;
    logic             step;

    always_comb begin
        c_d         = c_q;
        c_d.rst_req = 1'b0;
        div_lim     = ~({DIV_W{1'b1}} << c_q.ptv);
        step        = c_q.run && (!c_q.pre_en || (c_q.div == div_lim));

        if (c_q.run) begin
            c_d.div = (c_q.pre_en && (c_q.div != div_lim)) ? c_q.div + 1'b1 : '0;
        end

        if (step) begin
            if (&c_q.cnt) begin
                c_d.cnt     = c_q.load;
                c_d.rst_req = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end

        if (ctrl_apply) begin
            c_d.pre_en = ctrl_en;
            c_d.ptv    = ctrl_ptv;
            c_d.div    = '0;
        end

        if (load_apply) begin
            c_d.load = load_val;
        end

        if (kick_apply && (kick_val != c_q.last_kick)) begin
            c_d.cnt       = c_q.load;
            c_d.div       = '0;
            c_d.last_kick = kick_val;
        end

        if (arm_apply) begin
            c_d.seq = SEQ_IDLE;
            if ((c_q.seq == SEQ_ON_HALF) && (arm_val == DATA_W'(KEY_ON_B))) begin
                c_d.run = 1'b1;
                c_d.div = '0;
            end else if ((c_q.seq == SEQ_OFF_HALF) && (arm_val == DATA_W'(KEY_OFF_B))) begin
                c_d.run = 1'b0;
            end else if (arm_val == DATA_W'(KEY_ON_A)) begin
                c_d.seq = SEQ_ON_HALF;
            end else if (arm_val == DATA_W'(KEY_OFF_A)) begin
                c_d.seq = SEQ_OFF_HALF;
            end
        end

        c_d.gray = c_d.cnt ^ (c_d.cnt >> 1);
    end

    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            c_q     <= '0;
            c_q.seq <= SEQ_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_gray_o = c_q.gray;
    assign running_o    = c_q.run;
    assign seq_o        = c_q.seq;
    assign rst_req_o    = c_q.rst_req;

endmodule

// File: rtl/seqlock_wdt.sv
module seqlock_wdt
    import wdt_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          COUNT_W  = 32,
    parameter int          PTV_W    = 3,
    parameter logic [7:0]  REV_CODE = 8'h31
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    output logic              rst_req
);

    localparam int EN_BIT  = 2 + PTV_W;
    localparam int PTV_LSB = 2;

    typedef struct packed {
        logic [COUNT_W-1:0] g_m;
        logic [COUNT_W-1:0] g_s;
        logic               run_m;
        logic               run_s;
    } rd_sync_t;

    logic [NCHAN-1:0]  ch_wr;
    logic [NCHAN-1:0]  ch_busy;
    logic [NCHAN-1:0]  ch_apply;
    logic [DATA_W-1:0] ch_held [NCHAN];
    logic [PEND_W-1:0] pend;

    logic [COUNT_W-1:0] core_gray;
    logic               core_run;
    seq_e               core_seq;

    rd_sync_t rs_d, rs_q;

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        assign ch_wr[g] = wr_en && (addr == chan_addr(g)) && !ch_busy[g];

        wdt_post_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .bus_clk    (bus_clk),
            .bus_rst_n  (bus_rst_n),
            .wr_i       (ch_wr[g]),
            .wdata_i    (wdata),
            .busy_o     (ch_busy[g]),
            .held_o     (ch_held[g]),
            .slow_clk   (slow_clk),
            .slow_rst_n (slow_rst_n),
            .apply_o    (ch_apply[g])
        );
    end

    wdt_slow_core #(
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W),
        .PTV_W   (PTV_W)
    ) u_core (
        .slow_clk     (slow_clk),
        .slow_rst_n   (slow_rst_n),
        .ctrl_apply   (ch_apply[0]),
        .ctrl_en      (ch_held[0][EN_BIT]),
        .ctrl_ptv     (ch_held[0][PTV_LSB +: PTV_W]),
        .load_apply   (ch_apply[1]),
        .load_val     (ch_held[1][COUNT_W-1:0]),
        .kick_apply   (ch_apply[2]),
        .kick_val     (ch_held[2]),
        .arm_apply    (ch_apply[3]),
        .arm_val      (ch_held[3]),
        .count_gray_o (core_gray),
        .running_o    (core_run),
        .seq_o        (core_seq),
        .rst_req_o    (rst_req)
    );

    function automatic logic [COUNT_W-1:0] gray2bin(input logic [COUNT_W-1:0] g);
        logic [COUNT_W-1:0] b;
        b[COUNT_W-1] = g[COUNT_W-1];
        for (int i = COUNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        rs_d.g_m   = core_gray;
        rs_d.g_s   = rs_q.g_m;
        rs_d.run_m = core_run;
        rs_d.run_s = rs_q.run_m;
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) rs_q <= '0;
        else            rs_q <= rs_d;
    end

    always_comb begin
        pend = '0;
        for (int i = 0; i < NCHAN; i++) begin
            pend[chan_pend_bit(i)] = ch_busy[i];
        end
    end

    always_comb begin
        case (addr)
            A_IDENT: rdata = DATA_W'(REV_CODE);
            A_CTRL:  rdata = ch_held[0];
            A_COUNT: rdata = DATA_W'(gray2bin(rs_q.g_s));
            A_LOAD:  rdata = ch_held[1];
            A_KICK:  rdata = ch_held[2];
            A_ARM:   rdata = DATA_W'(rs_q.run_s);
            A_PEND:  rdata = DATA_W'(pend);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/seqlock_wdt_chk.sv
module seqlock_wdt_chk
    import wdt_pkg::*;
#(
    parameter int NC = 4
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              slow_clk,
    input logic              slow_rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NC-1:0]     busy,
    input logic              run,
    input seq_e              seq,
    input logic              rst_req
);

    // R5
    load_post_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_en && (addr == A_LOAD) && !busy[1]) |=> busy[1]);

    // R5
    kick_busy_src_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(busy[2]) |-> $past(wr_en && (addr == A_KICK)));

    // R2
    arm_key_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        $rose(run) |-> ($past(seq) == SEQ_ON_HALF));

    // R3
    disarm_key_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        $fell(run) |-> ($past(seq) == SEQ_OFF_HALF));

    // R8
    bite_armed_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        rst_req |-> $past(run));

endmodule

bind seqlock_wdt seqlock_wdt_chk #(
    .NC (wdt_pkg::NCHAN)
) u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .slow_clk   (slow_clk),
    .slow_rst_n (slow_rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .busy       (ch_busy),
    .run        (core_run),
    .seq        (core_seq),
    .rst_req    (rst_req)
);

// File: tb/test_seqlock_wdt.sv
module test_seqlock_wdt;
    import wdt_pkg::*;

    localparam int CW = 8;
    localparam int DW = 32;

    logic          bus_clk = 1'b0;
    logic          slow_clk = 1'b0;
    logic          bus_rst_n = 1'b0;
    logic          slow_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int slow_cyc = 0;
    int pulses = 0;
    int last_pulse = 0;
    int last_iv = 0;

    always #5 bus_clk = ~bus_clk;
    always #31 slow_clk = ~slow_clk;

    seqlock_wdt #(
        .DATA_W   (DW),
        .COUNT_W  (CW),
        .PTV_W    (3),
        .REV_CODE (8'h31)
    ) i_seqlock_wdt (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .rst_req    (rst_req)
    );

    always @(negedge slow_clk) begin
        slow_cyc++;
        if (rst_req === 1'b1) begin
            pulses++;
            last_iv = slow_cyc - last_pulse;
            last_pulse = slow_cyc;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1;
        addr = a;
        wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge bus_clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] v;
        do bread(A_PEND, v); while (v != '0);
        repeat (4) @(negedge bus_clk);
    endtask

    task automatic post(input logic [2:0] a, input logic [DW-1:0] d);
        bwrite(a, d);
        wait_idle();
    endtask

    task automatic measure(output int iv);
        int n0;
        n0 = pulses;
        wait (pulses >= n0 + 2);
        iv = last_iv;
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        logic [DW-1:0] v;
        int c1;
        int iv;

        repeat (4) @(negedge slow_clk);
        bus_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        repeat (3) @(negedge slow_clk);

        // Reset state
        bread(A_IDENT, v); check(v == 32'h31, "R1 identity", v, 32'h31);
        bread(A_PEND, v);  check(v == 0, "R5 pending after reset", v, 0);
        bread(A_ARM, v);   check(v == 0, "R2 armed after reset", v, 0);
        bread(A_COUNT, v); check(v == 0, "R7 count after reset", v, 0);

        // Posted write busy bit and dropped second write
        bwrite(A_LOAD, 32'h20);
        bread(A_PEND, v);  check(v == 32'h04, "R5 reload busy bit", v, 32'h04);
        bwrite(A_LOAD, 32'h30);
        wait_idle();
        bread(A_PEND, v);  check(v == 0, "R5 busy cleared", v, 0);
        bread(A_LOAD, v);  check(v == 32'h20, "R5 write while busy dropped", v, 32'h20);
        post(A_LOAD, 32'h10);

        bwrite(A_CTRL, 32'h2C);
        bread(A_PEND, v);  check(v == 32'h01, "R5 control busy bit", v, 32'h01);
        wait_idle();
        bread(A_CTRL, v);  check(v == 32'h2C, "R6 control readback", v, 32'h2C);

        bwrite(A_KICK, 32'h77);
        bread(A_PEND, v);  check(v == 32'h08, "R5 kick busy bit", v, 32'h08);
        wait_idle();
        bwrite(A_ARM, 32'h0);
        bread(A_PEND, v);  check(v == 32'h10, "R5 arm busy bit", v, 32'h10);
        wait_idle();

        // Disarmed: counter holds (kick reloaded it to 0x10)
        bread(A_COUNT, v); c1 = int'(v);
        repeat (60) @(negedge slow_clk);
        bread(A_COUNT, v); check(v == 32'h10 && int'(v) == c1, "R7 disarmed count holds", v, 32'h10);

        // Broken sequences
        post(A_ARM, 32'hBBBB); post(A_ARM, 32'h1234);
        bread(A_ARM, v);   check(v == 0, "R4 wrong second word", v, 0);
        post(A_ARM, 32'h4444);
        bread(A_ARM, v);   check(v == 0, "R4 lone partner word", v, 0);
        post(A_ARM, 32'hBBBB); post(A_ARM, 32'h5555);
        bread(A_ARM, v);   check(v == 0, "R4 cross partner word", v, 0);

        // Arm
        post(A_ARM, 32'hBBBB); post(A_ARM, 32'h4444);
        bread(A_ARM, v);   check(v == 1, "R2 armed", v, 1);

        // Kicks with prescale 8
        post(A_KICK, 32'h1234);
        bread(A_COUNT, v); check(v >= 32'h10 && v <= 32'h12, "R9 new kick reloads", v, 32'h10);
        repeat (330) @(negedge slow_clk);
        bread(A_COUNT, v); c1 = int'(v);
        check(c1 >= 32'h10 + 35 && c1 <= 32'h10 + 45, "R7 counting while armed", c1, 32'h10 + 40);
        post(A_KICK, 32'h1234);
        bread(A_COUNT, v); check(int'(v) >= c1, "R9 repeated kick ignored", v, c1);
        post(A_KICK, ~32'h1234);
        bread(A_COUNT, v); check(v >= 32'h10 && v <= 32'h12, "R9 inverted kick reloads", v, 32'h10);

        // Disarm
        post(A_ARM, 32'hAAAA); post(A_ARM, 32'h4444);
        bread(A_ARM, v);   check(v == 1, "R4 wrong disarm partner", v, 1);
        post(A_ARM, 32'hAAAA); post(A_ARM, 32'h5555);
        bread(A_ARM, v);   check(v == 0, "R3 disarmed", v, 0);
        bread(A_COUNT, v); c1 = int'(v);
        repeat (200) @(negedge slow_clk);
        bread(A_COUNT, v); check(int'(v) == c1, "R7 count frozen after disarm", v, c1);

        // Overflow spacing sweep over prescale exponents
        post(A_LOAD, 32'hF8);
        post(A_ARM, 32'hBBBB); post(A_ARM, 32'h4444);
        for (int p = 0; p < 8; p++) begin
            post(A_CTRL, (32'd1 << 5) | (p << 2));
            measure(iv);
            check(iv == (8 << p), $sformatf("R6 R8 prescale exp %0d", p), iv, 8 << p);
        end
        post(A_CTRL, 32'd5 << 2);
        measure(iv);
        check(iv == 8, "R6 prescaler off ignores exponent", iv, 8);

        // Reload value sweep, prescaler off
        for (int k = 0; k < 4; k++) begin
            int ld;
            ld = (k == 0) ? 32'h00 : (k == 1) ? 32'h80 : (k == 2) ? 32'hF0 : 32'hFF;
            post(A_LOAD, ld);
            measure(iv);
            check(iv == 256 - ld, $sformatf("R8 reload 0x%0h spacing", ld), iv, 256 - ld);
        end

        post(A_ARM, 32'hAAAA); post(A_ARM, 32'h5555);
        bread(A_ARM, v);   check(v == 0, "R3 final disarm", v, 0);

        summary();
    end

endmodule